// File: doc/BRIEF.md
# Three-Phase Current Reference Generator

This block turns a phase angle and a current amplitude into the three line-current commands used by the inner current loop of a three-level unidirectional rectifier. An 8-bit phase word from an external phase-locked counter selects a point on one line period, which is 256 steps long. A quarter-wave sine table yields three unit sinusoids 120 degrees apart. Each sinusoid is scaled by the signed amplitude that the DC-bus voltage regulator supplies.

A neutral-point balancing offset is then added equally to all three phases. It is formed from the two averaged DC-capacitor voltages, multiplied by a programmable gain and clamped to a programmable bound. A positive offset appears whenever the lower capacitor holds more voltage than the upper one. That offset drives the upper capacitor's voltage back up over the following line period.

One table and one multiplier serve all three phases, one after another, under a four-state controller:
- S_IDLE waits for a strobe. On a strobe it captures the phase, the amplitude and the clamped offset, and moves to S_PH_A.
- S_PH_A forms phase A and always moves on to S_PH_B.
- S_PH_B forms phase B and always moves on to S_PH_C.
- S_PH_C forms phase C, loads all three outputs together and returns to S_IDLE.

Top module: `iref3_gen`

## Requirements
- R1: While reset is held, on each clock edge all three commands become 0. The first strobe after reset is released is accepted.
- R2: The unit sine for table index p (0 to 255) is a Q1.15 value within one LSB of round(32767 * sin(2*pi*p/256)). It is odd-symmetric, so negative values are exact negatives of positive ones.
- R3: Phase A uses index p. Phase B uses (p + 171) mod 256, which is about minus 120 degrees. Phase C uses (p + 85) mod 256, which is about plus 120 degrees.
- R4: Each command equals floor(amp * unit / 32768) + offset. Here amp is the signed Q8.8 amplitude, and the result is a signed Q8.8 value within one LSB.
- R5: The raw offset is floor((vc_lower - vc_upper) * np_gain / 65536). The voltages are signed 16-bit values, and np_gain is an unsigned Q0.16 gain.
- R6: The raw offset is clamped to the range from -np_limit to +np_limit, where np_limit is an unsigned 15-bit value. A limit of 0 removes the offset entirely.
- R7: The same offset is added to all three phases. When vc_lower exceeds vc_upper the offset is zero or positive, and when it is below vc_upper the offset is negative.
- R8: Each final sum saturates to the range -32768 to 32767 and never wraps.
- R9: After a strobe is sampled on a rising edge, all three commands change together on the third following rising edge. Until then they keep their previous values.
- R10: The commands hold between updates. A strobe is ignored while a computation is in progress, including the edge that commits it. A strobe on the next edge after that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Request to compute a new set of commands |
| phase_word | input | 8 | Line angle, 256 steps per period |
| amp_cmd | input | 16 | Signed Q8.8 current amplitude |
| vc_upper | input | 16 | Signed averaged voltage of the upper DC capacitor |
| vc_lower | input | 16 | Signed averaged voltage of the lower DC capacitor |
| np_gain | input | 16 | Unsigned Q0.16 balancing gain |
| np_limit | input | 15 | Unsigned bound on the balancing offset |
| ref_a | output | 16 | Signed Q8.8 command, phase A |
| ref_b | output | 16 | Signed Q8.8 command, phase B |
| ref_c | output | 16 | Signed Q8.8 command, phase C |

## Verification
A full sweep of the phase word at maximum amplitude with zero offset checks the table folding and the 171/85 rotations. A swapped or misrotated phase shows up at once in that sweep. Runs with zero amplitude isolate the balancing path, so its gain, sign, symmetric clamp and zero limit can be read directly from three equal outputs. Amplitudes and offsets near full scale separate saturation from wraparound. Strobes held high through a computation, along with long runs of random strobes and random inputs, separate the three-edge latency and the busy-time ignoring from any design that samples its inputs late or restarts early.

// File: rtl/iref_pkg.sv
package iref_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PH_A = 2'd1,
        S_PH_B = 2'd2,
        S_PH_C = 2'd3
    } iref_state_e;

    // pi in Q30
    localparam longint PI_Q30 = 64'sd3373259426;

    // Sine of (pi/2 * k / quarter_len), scaled by (2^frac_w - 1), rounded.
    // Integer Taylor series in Q30, terms up to x^11.
    function automatic longint unit_sine_fix(input int k, input int quarter_len, input int frac_w);
        longint x;
        longint term;
        longint acc;
        x    = (PI_Q30 * longint'(k)) / longint'(2 * quarter_len);
        acc  = x;
        term = x;
        for (int n = 1; n <= 5; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return ((acc * ((longint'(1) <<< frac_w) - 1)) + (longint'(1) <<< 29)) >>> 30;
    endfunction

endpackage

// File: rtl/iref_sine_lut.sv
module iref_sine_lut #(
    parameter int PHASE_W = 8,
    parameter int SINE_W  = 16
) (
    input  logic [PHASE_W-1:0]       angle,
    output logic signed [SINE_W-1:0] unit
);
    localparam int QB = PHASE_W - 2;
    localparam int QN = 1 << QB;

    logic signed [SINE_W-1:0] qtab [0:QN];

    for (genvar k = 0; k <= QN; k++) begin : g_tab
        assign qtab[k] = SINE_W'(iref_pkg::unit_sine_fix(k, QN, SINE_W - 1));
    end

    logic [1:0]               quad;
    logic [QB-1:0]            off;
    logic [QB:0]              addr;
    logic signed [SINE_W-1:0] mag;

    always_comb begin
        quad = angle[PHASE_W-1 -: 2];
        off  = angle[QB-1:0];
        // odd quadrants run the quarter wave backwards
        addr = quad[0] ? ((QB+1)'(QN) - {1'b0, off}) : {1'b0, off};
        mag  = qtab[addr];
        // second half period is the negated first half
        unit = quad[1] ? -mag : mag;
    end

endmodule

// File: rtl/iref_np_comp.sv
module iref_np_comp #(
    parameter int DATA_W = 16,
    parameter int GAIN_W = 16,
    parameter int LIM_W  = 15,
    parameter int COMP_W = DATA_W + 2
) (
    input  logic signed [DATA_W-1:0] vc_upper,
    input  logic signed [DATA_W-1:0] vc_lower,
    input  logic [GAIN_W-1:0]        gain,
    input  logic [LIM_W-1:0]         limit,
    output logic signed [COMP_W-1:0] comp
);
    localparam int DIFF_W = DATA_W + 1;
    localparam int PROD_W = DIFF_W + GAIN_W + 1;

    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] bound;

    always_comb begin
        diff   = DIFF_W'(vc_lower) - DIFF_W'(vc_upper);
        prod   = PROD_W'(diff) * PROD_W'($signed({1'b0, gain}));
        scaled = prod >>> GAIN_W;
        bound  = PROD_W'($signed({1'b0, limit}));
        if (scaled > bound) begin
            comp = COMP_W'(bound);
        end else if (scaled < -bound) begin
            comp = COMP_W'(-bound);
        end else begin
            comp = COMP_W'(scaled);
        end
    end

endmodule

// File: rtl/iref_scale_sum.sv
module iref_scale_sum #(
    parameter int DATA_W = 16,
    parameter int SINE_W = 16,
    parameter int COMP_W = DATA_W + 2
) (
    input  logic signed [DATA_W-1:0] amp,
    input  logic signed [SINE_W-1:0] unit,
    input  logic signed [COMP_W-1:0] comp,
    output logic signed [DATA_W-1:0] cmd
);
    localparam int PROD_W = DATA_W + SINE_W;
    localparam int SUM_W  = ((PROD_W > COMP_W) ? PROD_W : COMP_W) + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        prod = PROD_W'(amp) * PROD_W'(unit);
        sum  = SUM_W'(prod >>> (SINE_W - 1)) + SUM_W'(comp);
        if (sum > HI) begin
            cmd = DATA_W'(HI);
        end else if (sum < LO) begin
            cmd = DATA_W'(LO);
        end else begin
            cmd = DATA_W'(sum);
        end
    end

endmodule

// File: rtl/iref3_gen.sv
module iref3_gen #(
    parameter int PHASE_W = 8,
    parameter int DATA_W  = 16,
    parameter int SINE_W  = 16,
    parameter int GAIN_W  = 16,
    parameter int LIM_W   = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_stb,
    input  logic [PHASE_W-1:0]       phase_word,
    input  logic signed [DATA_W-1:0] amp_cmd,
    input  logic signed [DATA_W-1:0] vc_upper,
    input  logic signed [DATA_W-1:0] vc_lower,
    input  logic [GAIN_W-1:0]        np_gain,
    input  logic [LIM_W-1:0]         np_limit,
    output logic signed [DATA_W-1:0] ref_a,
    output logic signed [DATA_W-1:0] ref_b,
    output logic signed [DATA_W-1:0] ref_c
);
    import iref_pkg::*;

    localparam int COMP_W = DATA_W + 2;
    localparam int PERIOD = 1 << PHASE_W;
    localparam int OFF_B  = (2 * PERIOD + 1) / 3;   // about -120 degrees
    localparam int OFF_C  = (PERIOD + 1) / 3;       // about +120 degrees

    iref_state_e state, state_nx;

    logic [PHASE_W-1:0]       phase_q;
    logic signed [DATA_W-1:0] amp_q;
    logic signed [COMP_W-1:0] comp_q;
    logic signed [DATA_W-1:0] sum_a_q, sum_b_q;
    logic signed [DATA_W-1:0] ref_a_q, ref_b_q, ref_c_q;

    logic [PHASE_W-1:0]       angle;
    logic signed [SINE_W-1:0] unit;
    logic signed [COMP_W-1:0] comp_now;
    logic signed [DATA_W-1:0] sum_now;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: state_nx = sample_stb ? S_PH_A : S_IDLE;
            S_PH_A: state_nx = S_PH_B;
            S_PH_B: state_nx = S_PH_C;
            S_PH_C: state_nx = S_IDLE;
        endcase
    end

    // ---------------- shared table address ----------------
    always_comb begin
        angle = phase_q;
        unique case (state)
            S_IDLE: angle = phase_q;
            S_PH_A: angle = phase_q;
            S_PH_B: angle = phase_q + PHASE_W'(OFF_B);
            S_PH_C: angle = phase_q + PHASE_W'(OFF_C);
        endcase
    end

    iref_sine_lut #(
        .PHASE_W (PHASE_W),
        .SINE_W  (SINE_W)
    ) u_lut (
        .angle (angle),
        .unit  (unit)
    );

    iref_np_comp #(
        .DATA_W (DATA_W),
        .GAIN_W (GAIN_W),
        .LIM_W  (LIM_W),
        .COMP_W (COMP_W)
    ) u_comp (
        .vc_upper (vc_upper),
        .vc_lower (vc_lower),
        .gain     (np_gain),
        .limit    (np_limit),
        .comp     (comp_now)
    );

    iref_scale_sum #(
        .DATA_W (DATA_W),
        .SINE_W (SINE_W),
        .COMP_W (COMP_W)
    ) u_sum (
        .amp  (amp_q),
        .unit (unit),
        .comp (comp_q),
        .cmd  (sum_now)
    );

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            amp_q   <= '0;
            comp_q  <= '0;
            sum_a_q <= '0;
            sum_b_q <= '0;
            ref_a_q <= '0;
            ref_b_q <= '0;
            ref_c_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (sample_stb) begin
                        phase_q <= phase_word;
                        amp_q   <= amp_cmd;
                        comp_q  <= comp_now;
                    end
                end
                S_PH_A: sum_a_q <= sum_now;
                S_PH_B: sum_b_q <= sum_now;
                S_PH_C: begin
                    ref_a_q <= sum_a_q;
                    ref_b_q <= sum_b_q;
                    ref_c_q <= sum_now;
                end
            endcase
        end
    end

    assign ref_a = ref_a_q;
    assign ref_b = ref_b_q;
    assign ref_c = ref_c_q;

    // ---------------- assertions ----------------
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ref_a == '0 && ref_b == '0 && ref_c == '0)); // R1

    AST_STB_STARTS: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && sample_stb) |=> (state == S_PH_A)); // R9

    AST_A_TO_B: assert property (@(posedge clk) disable iff (rst)
        (state == S_PH_A) |=> (state == S_PH_B)); // R9

    AST_B_TO_C: assert property (@(posedge clk) disable iff (rst)
        (state == S_PH_B) |=> (state == S_PH_C)); // R9

    AST_C_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == S_PH_C) |=> (state == S_IDLE)); // R10

    AST_HOLD_CMDS: assert property (@(posedge clk) disable iff (rst)
        (state != S_PH_C) |=> ($stable(ref_a) && $stable(ref_b) && $stable(ref_c))); // R10

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> ($stable(phase_q) && $stable(amp_q) && $stable(comp_q))); // R10

    AST_COMP_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && sample_stb) |=>
            (comp_q <= $signed(COMP_W'($past(np_limit))) &&
             comp_q >= -$signed(COMP_W'($past(np_limit))))); // R6

endmodule

// File: tb/iref3_gen_bench.sv
module iref3_gen_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic               stb;
    logic [7:0]         ph;
    logic signed [15:0] amp;
    logic signed [15:0] vu;
    logic signed [15:0] vl;
    logic [15:0]        k;
    logic [14:0]        lim;
    logic signed [15:0] ra, rb, rc;

    iref3_gen u_iref3_gen (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (stb),
        .phase_word (ph),
        .amp_cmd    (amp),
        .vc_upper   (vu),
        .vc_lower   (vl),
        .np_gain    (k),
        .np_limit   (lim),
        .ref_a      (ra),
        .ref_b      (rb),
        .ref_c      (rc)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // ---------------- reference functions ----------------
    function automatic longint unit_ref(int p);
        real v;
        v = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(p) / 256.0);
        if (v >= 0.0) return longint'($rtoi(v + 0.5));
        return longint'($rtoi(v - 0.5));
    endfunction

    function automatic longint comp_ref(longint up, longint lo, longint g, longint l);
        longint r;
        r = ((lo - up) * g) >>> 16;
        if (r > l) r = l;
        if (r < -l) r = -l;
        return r;
    endfunction

    function automatic longint cmd_ref(int p, longint a, longint c);
        longint s;
        s = ((a * unit_ref(p % 256)) >>> 15) + c;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // ---------------- cycle model ----------------
    int     busy;
    longint pend_a, pend_b, pend_c;
    longint exp_a, exp_b, exp_c;

    always @(posedge clk) begin
        longint c;
        if (rst) begin
            busy  = 0;
            exp_a = 0;
            exp_b = 0;
            exp_c = 0;
        end else if (busy != 0) begin
            busy = busy - 1;
            if (busy == 0) begin
                exp_a = pend_a;
                exp_b = pend_b;
                exp_c = pend_c;
            end
        end else if (stb) begin
            c      = comp_ref(longint'(vu), longint'(vl), longint'(k), longint'(lim));
            pend_a = cmd_ref(int'(ph), longint'(amp), c);
            pend_b = cmd_ref(int'(ph) + 171, longint'(amp), c);
            pend_c = cmd_ref(int'(ph) + 85, longint'(amp), c);
            busy   = 3;
        end
    end

    task automatic check(string req, string what, longint act, longint exp, longint tol);
        n_vec++;
        if (act - exp > tol || exp - act > tol) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "ref_a", longint'(ra), exp_a, 1);
            check(cur_req, "ref_b", longint'(rb), exp_b, 1);
            check(cur_req, "ref_c", longint'(rc), exp_c, 1);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic drive(int p, int a, int v1, int v2, int g, int l);
        ph  = 8'(p);
        amp = 16'(a);
        vu  = 16'(v1);
        vl  = 16'(v2);
        k   = 16'(g);
        lim = 15'(l);
    endtask

    // strobe once and wait until the commit is visible
    task automatic apply(int p, int a, int v1, int v2, int g, int l);
        drive(p, a, v1, v2, g, l);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        longint old_a;
        longint want;
        int unsigned seed;
        rst = 1'b1;
        stb = 1'b0;
        drive(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset clears the commands
        check("R1", "ref_a reset", longint'(ra), 0, 0);
        check("R1", "ref_b reset", longint'(rb), 0, 0);
        check("R1", "ref_c reset", longint'(rc), 0, 0);
        rst = 1'b0;

        // R1 / R2: first strobe after reset, quarter and three-quarter points
        cur_req = "R2";
        apply(64, 256, 0, 0, 0, 0);
        check("R2", "peak", longint'(ra), 255, 1);
        apply(192, 256, 0, 0, 0, 0);
        check("R2", "trough", longint'(ra), -256, 1);
        apply(0, 256, 0, 0, 0, 0);
        check("R2", "zero crossing", longint'(ra), 0, 1);

        // R3: full sweep at large amplitude
        cur_req = "R3";
        for (int p = 0; p < 256; p++) begin
            apply(p, 32767, 0, 0, 0, 0);
        end
        apply(0, 4096, 0, 0, 0, 0);
        check("R3", "phase B lags", longint'(rb), cmd_ref(171, 4096, 0), 1);
        check("R3", "phase C leads", longint'(rc), cmd_ref(85, 4096, 0), 1);

        // R4: several amplitudes including negative full scale
        cur_req = "R4";
        apply(37, 12345, 0, 0, 0, 0);
        check("R4", "scaled a", longint'(ra), cmd_ref(37, 12345, 0), 1);
        apply(37, -777, 0, 0, 0, 0);
        check("R4", "scaled neg", longint'(ra), cmd_ref(37, -777, 0), 1);
        apply(200, -32768, 0, 0, 0, 0);
        check("R4", "scaled min", longint'(rb), cmd_ref(200 + 171, -32768, 0), 1);

        // R5 / R7: balancing offset alone, both signs
        cur_req = "R5";
        apply(10, 0, 1000, 3000, 1966, 32767);
        check("R5", "offset a", longint'(ra), 59, 0);
        check("R7", "offset b equal", longint'(rb), longint'(ra), 0);
        check("R7", "offset c equal", longint'(rc), longint'(ra), 0);
        cur_req = "R7";
        apply(10, 0, 3000, 1000, 1966, 32767);
        check("R7", "negative offset", longint'(ra), -60, 0);
        check("R7", "negative offset c", longint'(rc), -60, 0);

        // R6: symmetric clamp and zero limit
        cur_req = "R6";
        apply(99, 0, -30000, 30000, 65535, 100);
        check("R6", "clamp high", longint'(rb), 100, 0);
        apply(99, 0, 30000, -30000, 65535, 100);
        check("R6", "clamp low", longint'(rc), -100, 0);
        apply(99, 0, -30000, 30000, 65535, 0);
        check("R6", "zero limit", longint'(ra), 0, 0);

        // R8: saturation at both ends
        cur_req = "R8";
        apply(64, 32767, -20000, 20000, 32768, 32767);
        check("R8", "sat high", longint'(ra), 32767, 0);
        apply(64, -32768, 20000, -20000, 32768, 32767);
        check("R8", "sat low", longint'(ra), -32768, 0);

        // R9: commit on the third edge after the strobe edge
        cur_req = "R9";
        apply(64, 256, 0, 0, 0, 0);
        old_a = longint'(ra);
        want  = cmd_ref(192, 512, 0);
        drive(192, 512, 0, 0, 0, 0);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        check("R9", "hold after 1 edge", longint'(ra), old_a, 0);
        @(negedge clk);
        check("R9", "hold after 2 edges", longint'(ra), old_a, 0);
        @(negedge clk);
        check("R9", "hold after 3rd-edge wait start", longint'(ra), old_a, 0);
        @(negedge clk);
        check("R9", "update after 3 edges", longint'(ra), want, 1);

        // R10: strobes while busy are ignored
        cur_req = "R10";
        want = cmd_ref(30, 20000, 0);
        drive(30, 20000, 0, 0, 0, 0);
        stb = 1'b1;
        @(negedge clk);
        drive(150, -9000, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        stb = 1'b0;
        @(negedge clk);
        check("R10", "first strobe wins", longint'(ra), want, 1);
        repeat (6) @(negedge clk);
        check("R10", "busy strobes dropped", longint'(ra), want, 1);

        // R10: random strobes and inputs
        seed = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            drive(int'(seed[31:24]), int'($signed(seed[23:8])), int'($signed(seed[15:0])),
                  int'($signed(seed[27:12])), int'(seed[19:4]), int'(seed[30:16]));
            stb = seed[5];
            @(negedge clk);
        end
        stb = 1'b0;
        repeat (5) @(negedge clk);

        finish_run();
    end

endmodule